// File: doc/BRIEF.md
# Phase-Multiplexed Processor Bus Interface

This block connects a processor core to a package with few pins. A 16-bit address and an 8-bit data bus share two 8-bit pin groups, and each clock period is split into two halves. In the low half of the clock the block drives the address: the dedicated output group carries the low address byte and the bidirectional group carries the high address byte. In the high half the dedicated group carries a status word with a fetch-marker flag and a read/write flag. The bidirectional group then carries the data byte, driven by the block on a write and released on a read. The bidirectional group is exposed as separate input, output and output-enable signals for the pad ring.

The core issues byte or 16-bit transactions through a request/acknowledge interface. A 16-bit transaction becomes two byte cycles, even address first. Read bytes are captured on the falling clock edge that closes each data phase, and all state advances on falling edges. An active-high ready input stretches the current bus cycle for as long as it is low. Two active-low interrupt inputs pass through two-flop synchronizers. The maskable one is reported as a level. The non-maskable one is turned into a sticky pending flag on each falling edge, and the core clears that flag with an acknowledge pulse.

Top module: `phase_bus_if`

## Requirements
- R1: During the low clock half, `pin_o` equals address bits 7:0, `pin_io_o` equals address bits 15:8, and `pin_io_oe` is 1.
- R2: During the high clock half, `pin_o` equals {6'b0, sync, rwb}, where bit 0 (rwb) is 1 for a read or an idle cycle and 0 for a write, and bit 1 is sync.
- R3: During the high clock half of a write cycle, `pin_io_oe` is 1 and `pin_io_o` carries the write byte. During the high half of a read or idle cycle, `pin_io_oe` is 0.
- R4: Sync (status bit 1) is 1 only in the bus cycle that reads the first byte of a request with `core_fetch`=1 and `core_we`=0. It is 0 on the second byte of a 16-bit fetch and on every write.
- R5: A byte read returns {8'h00, byte}, where the byte is sampled from `pin_io_i` at the falling edge that ends the data phase. `core_ack` is high for exactly one clock period after the last byte cycle completes.
- R6: A request with `core_wide`=1 makes two byte cycles, first at address {addr[15:1],0} with data bits 7:0, then at {addr[15:1],1} with data bits 15:8. A wide read returns {second byte, first byte}.
- R7: While `rdy` is 0 at a falling edge that would end a bus cycle, that cycle repeats with identical pin values, and `core_stall` is 1. The cycle completes at the first falling edge at which `rdy` is 1.
- R8: `irq_active` is the synchronized inverse of `irq_n`. It follows a level change after at most three falling edges.
- R9: A high-to-low transition of `nmi_n` sets `nmi_pending` within four falling edges. The flag stays set until `nmi_ack` is sampled high at a falling edge. Holding `nmi_n` low does not set it again; only a new falling transition does.
- R10: Without an outstanding transaction, `core_busy` is 0 and every high clock half shows status 8'h01 with `pin_io_oe` 0.
- R11: After reset, address is 16'h0000, `core_busy`, `core_ack`, `irq_active` and `nmi_pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; low half is address phase, high half is data phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_req | input | 1 | Transaction request, held until `core_ack` |
| core_we | input | 1 | 1 = write, 0 = read |
| core_wide | input | 1 | 1 = 16-bit transaction split into two byte cycles |
| core_fetch | input | 1 | Read is the start of an instruction |
| core_addr | input | 16 | Transaction address |
| core_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| core_rdata | output | 16 | Read result |
| core_ack | output | 1 | One-period completion pulse |
| core_busy | output | 1 | A transaction is in progress |
| core_stall | output | 1 | The current bus cycle is being held by `rdy` |
| irq_active | output | 1 | Synchronized maskable interrupt level |
| nmi_pending | output | 1 | Latched non-maskable interrupt |
| nmi_ack | input | 1 | Clears `nmi_pending` |
| irq_n | input | 1 | Active-low level interrupt request (asynchronous) |
| nmi_n | input | 1 | Active-low edge interrupt request (asynchronous) |
| rdy | input | 1 | Active-high ready; low holds the bus cycle |
| pin_o | output | 8 | Dedicated output pin group |
| pin_io_o | output | 8 | Bidirectional pin group, output value |
| pin_io_oe | output | 1 | Bidirectional pin group, output enable |
| pin_io_i | input | 8 | Bidirectional pin group, input value |

## Verification
The assertions rely on a few properties of the inputs:
- The core keeps request fields stable from `core_req` until `core_ack` and never raises a request while one is outstanding.
- `rdy` and `pin_io_i` do not change close to a falling edge.
- `nmi_ack` is a single-period pulse.

The bench keeps within these limits as follows. It changes core inputs, `rdy` and the interrupt lines only in the middle of a clock half. It updates `pin_io_i` in the middle of the address half, from a memory function of the address just seen. It drops the request in the same half period in which the acknowledge first appears.

// File: rtl/phase_bus_if_pkg.sv
package phase_bus_if_pkg;

  // Bus sequencer states: no cycle, first (or only) byte, second byte of a wide access
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pbif_sync.sv
// Multi-stage synchronizer clocked on the falling edge (bus-cycle boundary).
module pbif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pbif_irq_cond.sv
// Interrupt conditioning: level request and sticky edge request.
module pbif_irq_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic nmi_n,
  input  logic nmi_ack,
  output logic irq_active,
  output logic nmi_pending
);

  logic irq_s;
  logic nmi_s;
  logic nmi_prev_q;
  logic nmi_pend_q, nmi_pend_d;
  logic nmi_fall;

  pbif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_n), .q(irq_s)
  );

  pbif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_s)
  );

  always_comb begin
    nmi_fall   = nmi_prev_q & ~nmi_s;
    nmi_pend_d = nmi_pend_q;
    if (nmi_ack)  nmi_pend_d = 1'b0;
    if (nmi_fall) nmi_pend_d = 1'b1;   // a new edge wins over a clear
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_s;
      nmi_pend_q <= nmi_pend_d;
    end
  end

  assign irq_active  = ~irq_s;
  assign nmi_pending = nmi_pend_q;

  // R9
  nmi_sticky_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (nmi_pend_q && !nmi_ack) |=> nmi_pend_q);

  // R9
  nmi_rise_cause_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(nmi_pend_q) |-> $past(nmi_prev_q && !nmi_s));

endmodule

// File: rtl/pbif_bus_seq.sv
// Bus-cycle sequencer: accepts core transactions, splits wide ones,
// honours ready, captures read bytes at the falling edge.
module pbif_bus_seq
  import phase_bus_if_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                we,
  input  logic                wide,
  input  logic                fetch,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*BYTE_W-1:0] wdata,
  input  logic                rdy,
  input  logic [BYTE_W-1:0]   pin_rd,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_we,
  output logic                bus_sync,
  output logic [BYTE_W-1:0]   bus_wbyte,
  output logic                bus_active,
  output logic                ack,
  output logic [2*BYTE_W-1:0] rdata
);

  localparam int WORD_W = 2 * BYTE_W;

  seq_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                we_q, we_d;
  logic                wide_q, wide_d;
  logic                sync_q, sync_d;
  logic [WORD_W-1:0]   wdat_q, wdat_d;
  logic [BYTE_W-1:0]   lo_q, lo_d;
  logic [WORD_W-1:0]   rdata_q, rdata_d;
  logic                ack_q, ack_d;
  logic                accept;
  logic                step;
  logic                cyc_en;

  always_comb begin
    accept = (state_q == SEQ_IDLE) && req;
    step   = (state_q != SEQ_IDLE) && rdy;
    cyc_en = accept || step;
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    we_d    = we_q;
    wide_d  = wide_q;
    sync_d  = sync_q;
    wdat_d  = wdat_q;
    lo_d    = lo_q;
    rdata_d = rdata_q;
    ack_d   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req) begin
          state_d = SEQ_FIRST;
          addr_d  = wide ? {addr[ADDR_W-1:1], 1'b0} : addr;
          we_d    = we;
          wide_d  = wide;
          sync_d  = fetch & ~we;
          wdat_d  = wdata;
        end
      end
      SEQ_FIRST: begin
        if (rdy) begin
          if (!we_q) lo_d = pin_rd;
          if (wide_q) begin
            state_d   = SEQ_SECOND;
            addr_d[0] = 1'b1;
            sync_d    = 1'b0;
          end else begin
            state_d = SEQ_IDLE;
            sync_d  = 1'b0;
            ack_d   = 1'b1;
            if (!we_q) rdata_d = {{BYTE_W{1'b0}}, pin_rd};
          end
        end
      end
      SEQ_SECOND: begin
        if (rdy) begin
          state_d = SEQ_IDLE;
          ack_d   = 1'b1;
          if (!we_q) rdata_d = {pin_rd, lo_q};
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // Control state and completion pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  // Cycle descriptor, loaded only when a cycle starts or advances
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      sync_q  <= 1'b0;
      wdat_q  <= '0;
      lo_q    <= '0;
      rdata_q <= '0;
    end else if (cyc_en) begin
      addr_q  <= addr_d;
      we_q    <= we_d;
      wide_q  <= wide_d;
      sync_q  <= sync_d;
      wdat_q  <= wdat_d;
      lo_q    <= lo_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_addr   = addr_q;
  assign bus_we     = we_q;
  assign bus_sync   = sync_q;
  assign bus_wbyte  = (state_q == SEQ_SECOND) ? wdat_q[WORD_W-1:BYTE_W] : wdat_q[BYTE_W-1:0];
  assign bus_active = (state_q != SEQ_IDLE);
  assign ack        = ack_q;
  assign rdata      = rdata_q;

  // R7
  hold_on_stall_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ((state_q != SEQ_IDLE) && !rdy) |=> ($stable(addr_q) && $stable(state_q) && $stable(we_q)));

  // R6
  second_odd_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (state_q == SEQ_SECOND) |-> addr_q[0]);

  // R6
  wide_order_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ((state_q == SEQ_FIRST) && wide_q && rdy) |=>
      ((state_q == SEQ_SECOND) && (addr_q == {$past(addr_q[ADDR_W-1:1]), 1'b1})));

  // R5
  ack_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R4
  sync_first_read_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (sync_q && (state_q != SEQ_IDLE)) |-> (!we_q && (state_q == SEQ_FIRST)));

endmodule

// File: rtl/pbif_pin_mux.sv
// Half-phase pin multiplexer: address while the clock is low,
// status and data while it is high.
module pbif_pin_mux #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              phase_hi,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_sync,
  input  logic [BYTE_W-1:0] bus_wbyte,
  input  logic              bus_active,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_io_o,
  output logic              pin_io_oe
);

  logic              rwb;
  logic              sync;
  logic              wr_cyc;
  logic [BYTE_W-1:0] status;

  always_comb begin
    wr_cyc = bus_active & bus_we;
    rwb    = ~wr_cyc;
    sync   = bus_active & bus_sync;
    status = {{(BYTE_W-2){1'b0}}, sync, rwb};
  end

  always_comb begin
    if (phase_hi) begin
      pin_o     = status;
      pin_io_o  = bus_wbyte;
      pin_io_oe = wr_cyc;
    end else begin
      pin_o     = bus_addr[BYTE_W-1:0];
      pin_io_o  = bus_addr[ADDR_W-1:BYTE_W];
      pin_io_oe = 1'b1;
    end
  end

endmodule

// File: rtl/phase_bus_if.sv
module phase_bus_if #(
  parameter int ADDR_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                core_req,
  input  logic                core_we,
  input  logic                core_wide,
  input  logic                core_fetch,
  input  logic [ADDR_W-1:0]   core_addr,
  input  logic [2*BYTE_W-1:0] core_wdata,
  output logic [2*BYTE_W-1:0] core_rdata,
  output logic                core_ack,
  output logic                core_busy,
  output logic                core_stall,
  output logic                irq_active,
  output logic                nmi_pending,
  input  logic                nmi_ack,
  input  logic                irq_n,
  input  logic                nmi_n,
  input  logic                rdy,
  output logic [BYTE_W-1:0]   pin_o,
  output logic [BYTE_W-1:0]   pin_io_o,
  output logic                pin_io_oe,
  input  logic [BYTE_W-1:0]   pin_io_i
);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic              bus_sync;
  logic [BYTE_W-1:0] bus_wbyte;
  logic              bus_active;

  // Reset: asserted asynchronously, released on a falling edge
  pbif_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pbif_bus_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .req(core_req), .we(core_we), .wide(core_wide), .fetch(core_fetch),
    .addr(core_addr), .wdata(core_wdata), .rdy(rdy), .pin_rd(pin_io_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_sync(bus_sync),
    .bus_wbyte(bus_wbyte), .bus_active(bus_active),
    .ack(core_ack), .rdata(core_rdata)
  );

  pbif_pin_mux #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mux (
    .phase_hi(clk), .bus_addr(bus_addr), .bus_we(bus_we), .bus_sync(bus_sync),
    .bus_wbyte(bus_wbyte), .bus_active(bus_active),
    .pin_o(pin_o), .pin_io_o(pin_io_o), .pin_io_oe(pin_io_oe)
  );

  pbif_irq_cond #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .nmi_ack(nmi_ack), .irq_active(irq_active), .nmi_pending(nmi_pending)
  );

  assign core_busy  = bus_active;
  assign core_stall = bus_active & ~rdy;

  // R10
  idle_no_ack_chk: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (!core_busy && !$past(core_busy)) |-> !core_ack);

endmodule

// File: tb/phase_bus_if_bench.sv
module phase_bus_if_bench;

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic        sync;
    logic [7:0]  wbyte;
  } bus_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_req, core_we, core_wide, core_fetch;
  logic [15:0] core_addr, core_wdata;
  logic [15:0] core_rdata;
  logic        core_ack, core_busy, core_stall;
  logic        irq_active, nmi_pending, nmi_ack;
  logic        irq_n, nmi_n, rdy;
  logic [7:0]  pin_o, pin_io_o, pin_io_i;
  logic        pin_io_oe;

  int        n_chk  = 0;
  int        n_fail = 0;
  bit        mon_on = 1'b0;
  bit        done   = 1'b0;
  bus_item_t exp_q[$];

  always #4 clk = ~clk;

  phase_bus_if u_phase_bus_if (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_wide(core_wide),
    .core_fetch(core_fetch), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_ack(core_ack), .core_busy(core_busy),
    .core_stall(core_stall), .irq_active(irq_active), .nmi_pending(nmi_pending),
    .nmi_ack(nmi_ack), .irq_n(irq_n), .nmi_n(nmi_n), .rdy(rdy),
    .pin_o(pin_o), .pin_io_o(pin_io_o), .pin_io_oe(pin_io_oe), .pin_io_i(pin_io_i)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard: one pass per clock period
  initial begin : monitor
    logic [15:0] seen_addr;
    logic        seen_oe;
    bus_item_t   it;
    forever begin
      @(negedge clk); #2;
      seen_addr = {pin_io_o, pin_o};
      seen_oe   = pin_io_oe;
      pin_io_i  = mem_byte(seen_addr);
      @(posedge clk); #2;
      if (mon_on) begin
        if (core_busy) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected bus cycle", seen_addr, 0);
          end else begin
            it = exp_q[0];
            check(seen_addr == it.addr, "R1", "address phase addr", seen_addr, it.addr);
            check(seen_oe == 1'b1, "R1", "address phase oe", seen_oe, 1);
            check(pin_o == {6'b0, it.sync, ~it.we}, "R2_R4", "status",
                  pin_o, {6'b0, it.sync, ~it.we});
            check(pin_io_oe == it.we, "R3", "data phase oe", pin_io_oe, it.we);
            if (it.we) check(pin_io_o == it.wbyte, "R3", "write byte", pin_io_o, it.wbyte);
            check(core_stall == ~rdy, "R7", "stall flag", core_stall, ~rdy);
            if (rdy) void'(exp_q.pop_front());
          end
        end else begin
          check(pin_o == 8'h01, "R10", "idle status", pin_o, 8'h01);
          check(pin_io_oe == 1'b0, "R10", "idle data oe", pin_io_oe, 0);
        end
      end
    end
  end

  // Driver: pushes expected bus cycles then runs one transaction
  task automatic xact(input bit we, input bit wide, input bit fetch,
                      input logic [15:0] a, input logic [15:0] wd, input int waits);
    bus_item_t   it;
    logic [15:0] ea;
    logic [15:0] exp_rd;
    ea = wide ? {a[15:1], 1'b0} : a;
    it.addr = ea; it.we = we; it.sync = fetch & ~we; it.wbyte = wd[7:0];
    exp_q.push_back(it);
    exp_rd = {8'h00, mem_byte(ea)};
    if (wide) begin
      it.addr = {a[15:1], 1'b1}; it.sync = 1'b0; it.wbyte = wd[15:8];
      exp_q.push_back(it);
      exp_rd = {mem_byte({a[15:1], 1'b1}), mem_byte(ea)};
    end
    @(posedge clk); #2;
    if (waits > 0) rdy = 1'b0;
    core_req = 1'b1; core_we = we; core_wide = wide; core_fetch = fetch;
    core_addr = a; core_wdata = wd;
    @(negedge clk);
    repeat (waits) @(negedge clk);
    #2 rdy = 1'b1;
    do begin
      @(posedge clk); #2;
    end while (!core_ack);
    core_req = 1'b0;
    if (!we) check(core_rdata == exp_rd, wide ? "R6" : "R5", "read result", core_rdata, exp_rd);
    @(posedge clk); #2;
    check(core_ack == 1'b0, "R5", "ack single pulse", core_ack, 0);
    check(exp_q.size() == 0, "R6", "bus cycles left", exp_q.size(), 0);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
    @(posedge clk); #2;
  endtask

  initial begin : stim
    rst_n = 1'b0; core_req = 1'b0; core_we = 1'b0; core_wide = 1'b0;
    core_fetch = 1'b0; core_addr = '0; core_wdata = '0; nmi_ack = 1'b0;
    irq_n = 1'b1; nmi_n = 1'b1; rdy = 1'b1; pin_io_i = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R11 / R1: reset address on the pins
    check({pin_io_o, pin_o} == 16'h0000, "R11", "reset address", {pin_io_o, pin_o}, 0);
    check(pin_io_oe == 1'b1, "R1", "reset addr oe", pin_io_oe, 1);
    @(posedge clk); #2;
    check(core_busy == 1'b0, "R11", "reset busy", core_busy, 0);
    check(core_ack == 1'b0, "R11", "reset ack", core_ack, 0);
    check(irq_active == 1'b0, "R11", "reset irq", irq_active, 0);
    check(nmi_pending == 1'b0, "R11", "reset nmi", nmi_pending, 0);
    check(pin_o == 8'h01, "R10", "reset status", pin_o, 8'h01);
    mon_on = 1'b1;

    xact(1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, 0);   // R5 byte read
    xact(1'b1, 1'b0, 1'b0, 16'hA5C3, 16'h00E7, 0);   // R3 byte write
    xact(1'b0, 1'b1, 1'b0, 16'h4001, 16'h0000, 0);   // R6 wide read, odd input
    xact(1'b1, 1'b1, 1'b0, 16'hFFFE, 16'hBEEF, 0);   // R6 wide write
    xact(1'b0, 1'b0, 1'b1, 16'h0200, 16'h0000, 0);   // R4 byte fetch
    xact(1'b0, 1'b1, 1'b1, 16'h8010, 16'h0000, 0);   // R4 wide fetch
    xact(1'b1, 1'b0, 1'b1, 16'h0300, 16'h0011, 0);   // R4 fetch flag ignored on write
    xact(1'b0, 1'b0, 1'b0, 16'h7777, 16'h0000, 3);   // R7 stalled read
    xact(1'b1, 1'b1, 1'b0, 16'h1000, 16'h55AA, 2);   // R7 stalled wide write
    xact(1'b0, 1'b1, 1'b0, 16'hC0DE, 16'h0000, 1);   // R7 stalled wide read

    // R8 level interrupt
    irq_n = 1'b0;
    wait_edges(3);
    check(irq_active == 1'b1, "R8", "irq asserted", irq_active, 1);
    irq_n = 1'b1;
    wait_edges(3);
    check(irq_active == 1'b0, "R8", "irq released", irq_active, 0);

    // R9 edge interrupt
    nmi_n = 1'b0;
    wait_edges(4);
    check(nmi_pending == 1'b1, "R9", "nmi latched", nmi_pending, 1);
    wait_edges(3);
    check(nmi_pending == 1'b1, "R9", "nmi stays until ack", nmi_pending, 1);
    nmi_ack = 1'b1;
    @(posedge clk); #2 nmi_ack = 1'b0;
    wait_edges(4);
    check(nmi_pending == 1'b0, "R9", "low level no retrigger", nmi_pending, 0);
    nmi_n = 1'b1;
    wait_edges(4);
    check(nmi_pending == 1'b0, "R9", "rising edge ignored", nmi_pending, 0);
    nmi_n = 1'b0;
    wait_edges(4);
    check(nmi_pending == 1'b1, "R9", "second edge latched", nmi_pending, 1);
    nmi_n = 1'b1;
    nmi_ack = 1'b1;
    @(posedge clk); #2 nmi_ack = 1'b0;
    wait_edges(2);
    check(nmi_pending == 1'b0, "R9", "ack clears", nmi_pending, 0);

    wait_edges(2);
    done = 1'b1;
  end

  initial begin : finisher
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule